// File: doc/BRIEF.md
# Convolution and Max-Pool Tile Engine

This engine produces one pooled activation of a 5x5 convolution layer that is followed by 2x2 max pooling. All operands are signed 8-bit values. When `start` is sampled, the engine latches the tile coordinates, the kernel index, the scale and the two base addresses. It then reads a 6x6 input window row by row through both read ports of a dual-port 32-bit activation memory. In the same cycles it reads the matching 5x5 kernel rows through both read ports of a dual-port 32-bit weight memory. Both memories have a read latency of one cycle.

From the window the engine forms the four overlapping 5x5 dot products. In deep mode it adds them over six input channels. Each of the four sums is then rescaled, saturated and rectified, and the largest of the four is presented on `result` together with a one-cycle `done` pulse.

Two input layouts are supported. In shallow mode the input is a single 32x32 map stored as eight words per row. In deep mode the input is six 14x14 maps stored as four words per row. A surrounding controller chooses the layer and writes the results back.

Top module: `tile_conv_pool`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `done` are 0 and `result` is 0.
- R2: A tile accepted at a clock edge keeps `busy` high for the next 12*C+1 cycles, where C is 1 in shallow mode and 6 in deep mode. `done` is then high for exactly one cycle with `busy` low, and the engine then returns to idle.
- R3: A `start` that arrives while `busy` is high is ignored and does not change the timing or the value of the running tile.
- R4: All tile inputs (mode, coordinates, kernel index, scale, base addresses) are latched at acceptance. Changing them later has no effect on the running tile.
- R5: Shallow mode (`deep_mode`=0). Window row i (0..5) is read at word address `act_base + (2*pool_row+i)*8 + pool_col/2` and at the next word. Byte k of a word sits in bits [8k+7:8k], with the lowest-index element in bits [7:0]. The window row starts at byte 2*(pool_col mod 2) of the 8-byte pair.
- R6: Deep mode (`deep_mode`=1). For channel c (0..5), window row i is read at word `act_base + (c*14 + 2*pool_row+i)*4 + pool_col/2` and at the next word. The byte placement is the same as in R5.
- R7: Kernel row i of channel c is stored as a word pair starting at `wgt_base + ((kern_idx*C + c)*5 + i)*2`. The first word holds weights 0..3 with the lowest index in bits [7:0]. The second word holds weight 4 in bits [7:0].
- R8: For each pooling position (dy,dx) in {0,1}x{0,1}, the sum is the signed 32-bit total, over channels and kernel taps, of window[i+dy][j+dx]*kernel[i][j]. `result` is the maximum of the four post-processed values.
- R9: Post-processing of one sum s proceeds in four steps. (1) Form s*scale as a signed 64-bit product. (2) Add 2^15 and shift arithmetically right by 16. (3) Saturate to [-128,127]. (4) Clamp negative values to 0.
- R10: A `start` that arrives in the cycle where `done` is high is accepted and begins the next tile without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to compute one tile |
| deep_mode | input | 1 | 0: one 32x32 channel, 1: six 14x14 channels |
| pool_row | input | 5 | Pooled output row |
| pool_col | input | 5 | Pooled output column |
| kern_idx | input | 4 | Output channel (kernel) index |
| scale | input | 32 | Signed rescale multiplier |
| act_base | input | 16 | Activation memory base word address |
| wgt_base | input | 16 | Weight memory base word address |
| act_addr0 | output | 16 | Activation read address, port 0 |
| act_addr1 | output | 16 | Activation read address, port 1 |
| act_rdata0 | input | 32 | Activation read data, port 0 |
| act_rdata1 | input | 32 | Activation read data, port 1 |
| wgt_addr0 | output | 16 | Weight read address, port 0 |
| wgt_addr1 | output | 16 | Weight read address, port 1 |
| wgt_rdata0 | input | 32 | Weight read data, port 0 |
| wgt_rdata1 | input | 32 | Weight read data, port 1 |
| busy | output | 1 | Tile in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Pooled, rectified activation |

## Verification
The completion pulse of one tile and the acceptance of the next can coincide. The bench provokes this by raising `start` in exactly the cycle that shows `done`. It then judges whether the behavioural model's cycle count and expected value for the second tile still match on every clock. A second collision is a `start` that arrives inside a running tile while all tile inputs are changed. That case is judged by checking that the first tile's timing and its value, computed from the originally latched inputs, are unchanged.

// File: rtl/tile_pkg.sv
// Package: shared geometry constants and the controller state type for the
// convolution/max-pool tile engine. Assumes a square 5x5 kernel, so the
// pooled window is 6x6.
package tile_pkg;
    localparam int BYTE_W        = 8;
    localparam int WORD_W        = 32;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int KDIM          = 5;
    localparam int WDIM          = KDIM + 1;
    localparam int NPOS          = 4;
    localparam int WORDS_PER_KROW = 2;
    localparam int CNT_W         = $clog2(WDIM);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_MAC,
        ST_POOL,
        ST_DONE
    } tile_state_t;
endpackage

// File: rtl/tile_addr_gen.sv
// Address generator: maps the latched tile description plus the current
// channel and fetch row onto two activation and two weight word addresses.
// Assumes the window row always fits in two consecutive words.
module tile_addr_gen
    import tile_pkg::*;
#(
    parameter int ADDR_W           = 16,
    parameter int POS_W            = 5,
    parameter int KERN_W           = 4,
    parameter int CH_W             = 3,
    parameter int DEEP_CH          = 6,
    parameter int MAP_DIM          = 14,
    parameter int WIDE_ROW_WORDS   = 8,
    parameter int NARROW_ROW_WORDS = 4
) (
    input  logic              md,
    input  logic [POS_W-1:0]  pr,
    input  logic [POS_W-1:0]  pc,
    input  logic [KERN_W-1:0] kern,
    input  logic [CH_W-1:0]   ch,
    input  logic [CNT_W-1:0]  frow,
    input  logic [ADDR_W-1:0] abase,
    input  logic [ADDR_W-1:0] wbase,
    output logic [ADDR_W-1:0] act_a0,
    output logic [ADDR_W-1:0] act_a1,
    output logic [ADDR_W-1:0] wgt_a0,
    output logic [ADDR_W-1:0] wgt_a1
);
    // Compute the word offsets of the current window row and kernel row.
    always_comb begin
        int row;
        int wcol;
        int aoff;
        int krow;
        int nch;
        int woff;
        row  = 2 * int'(pr) + int'(frow);
        wcol = int'(pc) >> 1;
        if (md)
            aoff = (int'(ch) * MAP_DIM + row) * NARROW_ROW_WORDS + wcol;
        else
            aoff = row * WIDE_ROW_WORDS + wcol;
        krow = (int'(frow) >= KDIM) ? KDIM - 1 : int'(frow);
        nch  = md ? DEEP_CH : 1;
        woff = ((int'(kern) * nch + int'(ch)) * KDIM + krow) * WORDS_PER_KROW;
        act_a0 = abase + ADDR_W'(aoff);
        act_a1 = act_a0 + ADDR_W'(1);
        wgt_a0 = wbase + ADDR_W'(woff);
        wgt_a1 = wgt_a0 + ADDR_W'(1);
    end
endmodule

// File: rtl/tile_window.sv
// Window store: captures one 6-byte window row from two activation words and
// one 5-byte kernel row from a weight word pair, one cycle after the fetch.
// Assumes the row starts at byte 0 or byte 2 of the 8-byte pair.
module tile_window
    import tile_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cap_vld,
    input  logic [CNT_W-1:0]                      cap_row,
    input  logic                                  col_odd,
    input  logic [WORD_W-1:0]                     act_rd0,
    input  logic [WORD_W-1:0]                     act_rd1,
    input  logic [WORD_W-1:0]                     wgt_rd0,
    input  logic [WORD_W-1:0]                     wgt_rd1,
    output logic [WDIM-1:0][WDIM-1:0][BYTE_W-1:0] win,
    output logic [KDIM-1:0][KDIM-1:0][BYTE_W-1:0] ker
);
    logic [2*WORD_W-1:0] pair;
    logic                pad_unused;

    assign pair       = {act_rd1, act_rd0};
    assign pad_unused = ^wgt_rd1[WORD_W-1:BYTE_W];

    // Load the addressed window row from the two-word activation pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (cap_vld) begin
            for (int r = 0; r < WDIM; r++) begin
                if (cap_row == CNT_W'(r)) begin
                    for (int j = 0; j < WDIM; j++)
                        win[r][j] <= pair[BYTE_W*j + (col_odd ? 2*BYTE_W : 0) +: BYTE_W];
                end
            end
        end
    end

    // Unpack the addressed kernel row: four bytes from word 0, one from word 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ker <= '0;
        end else if (cap_vld) begin
            for (int r = 0; r < KDIM; r++) begin
                if (cap_row == CNT_W'(r)) begin
                    for (int j = 0; j < BYTES_PER_WORD; j++)
                        ker[r][j] <= wgt_rd0[BYTE_W*j +: BYTE_W];
                    ker[r][KDIM-1] <= wgt_rd1[BYTE_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/tile_mac.sv
// Four-position accumulator: in each step it adds one kernel row's dot
// product for all four pooling positions. Assumes a clear before the first
// channel; partial sums carry across channels.
module tile_mac
    import tile_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  en,
    input  logic [CNT_W-1:0]                      step_row,
    input  logic [WDIM-1:0][WDIM-1:0][BYTE_W-1:0] win,
    input  logic [KDIM-1:0][KDIM-1:0][BYTE_W-1:0] ker,
    output logic [NPOS-1:0][ACC_W-1:0]            acc
);
    localparam int PROD_W = 2 * BYTE_W;

    logic signed [ACC_W-1:0] rowsum [NPOS];

    // Form the row dot product for every (dy,dx) pooling position.
    always_comb begin
        logic signed [PROD_W-1:0] prod;
        logic signed [ACC_W-1:0]  s;
        for (int p = 0; p < NPOS; p++) begin
            s = '0;
            for (int j = 0; j < KDIM; j++) begin
                prod = $signed(win[int'(step_row) + p/2][j + p%2]) * $signed(ker[step_row][j]);
                s    = s + ACC_W'(prod);
            end
            rowsum[p] = s;
        end
    end

    // Clear at tile start, otherwise add the row sums on each MAC step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            for (int p = 0; p < NPOS; p++)
                acc[p] <= acc[p] + rowsum[p];
        end
    end
endmodule

// File: rtl/tile_pool.sv
// Rescale and pool: scales each of the four sums, rounds, saturates to
// 8 bits, rectifies, and returns the largest. Purely combinational.
module tile_pool
    import tile_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int SC_W  = 32,
    parameter int SHIFT = 16
) (
    input  logic [NPOS-1:0][ACC_W-1:0] acc,
    input  logic [SC_W-1:0]            scale,
    output logic [BYTE_W-1:0]          pooled
);
    localparam int PROD_W = ACC_W + SC_W;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (SHIFT - 1);

    // Post-process each position and keep the running maximum.
    always_comb begin
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] shifted;
        logic signed [BYTE_W-1:0] sat;
        logic signed [BYTE_W-1:0] best;
        best = '0;
        for (int p = 0; p < NPOS; p++) begin
            prod    = $signed(acc[p]) * $signed(scale);
            shifted = (prod + HALF) >>> SHIFT;
            if (shifted > 127)
                sat = 8'sd127;
            else if (shifted < -128)
                sat = -8'sd128;
            else
                sat = shifted[BYTE_W-1:0];
            if (sat < 0)
                sat = '0;
            if (sat > best)
                best = sat;
        end
        pooled = best;
    end
endmodule

// File: rtl/tile_conv_pool.sv
// Top: sequences one pooled tile. Per channel it fetches six rows, drains one
// read cycle, then runs five MAC steps; after the last channel it pools and
// pulses done. Assumes memories with a one-cycle read latency.
module tile_conv_pool
    import tile_pkg::*;
#(
    parameter int ADDR_W           = 16,
    parameter int POS_W            = 5,
    parameter int KERN_W           = 4,
    parameter int ACC_W            = 32,
    parameter int SC_W             = 32,
    parameter int SCALE_SHIFT      = 16,
    parameter int DEEP_CH          = 6,
    parameter int MAP_DIM          = 14,
    parameter int WIDE_ROW_WORDS   = 8,
    parameter int NARROW_ROW_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              deep_mode,
    input  logic [POS_W-1:0]  pool_row,
    input  logic [POS_W-1:0]  pool_col,
    input  logic [KERN_W-1:0] kern_idx,
    input  logic [SC_W-1:0]   scale,
    input  logic [ADDR_W-1:0] act_base,
    input  logic [ADDR_W-1:0] wgt_base,
    output logic [ADDR_W-1:0] act_addr0,
    output logic [ADDR_W-1:0] act_addr1,
    input  logic [WORD_W-1:0] act_rdata0,
    input  logic [WORD_W-1:0] act_rdata1,
    output logic [ADDR_W-1:0] wgt_addr0,
    output logic [ADDR_W-1:0] wgt_addr1,
    input  logic [WORD_W-1:0] wgt_rdata0,
    input  logic [WORD_W-1:0] wgt_rdata1,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] result
);
    localparam int CH_W = $clog2(DEEP_CH + 1);

    tile_state_t       state;
    logic [CNT_W-1:0]  fcnt;
    logic [CNT_W-1:0]  mcnt;
    logic [CH_W-1:0]   ch;
    logic [CH_W-1:0]   last_ch;
    logic              md_q;
    logic [POS_W-1:0]  pr_q;
    logic [POS_W-1:0]  pc_q;
    logic [KERN_W-1:0] kern_q;
    logic [SC_W-1:0]   scale_q;
    logic [ADDR_W-1:0] abase_q;
    logic [ADDR_W-1:0] wbase_q;
    logic [BYTE_W-1:0] result_q;
    logic              cap_vld;
    logic [CNT_W-1:0]  cap_row;
    logic              accept;
    logic [BYTE_W-1:0] pooled;

    logic [WDIM-1:0][WDIM-1:0][BYTE_W-1:0] win;
    logic [KDIM-1:0][KDIM-1:0][BYTE_W-1:0] ker;
    logic [NPOS-1:0][ACC_W-1:0]            acc;

    assign accept  = start && (state == ST_IDLE || state == ST_DONE);
    assign last_ch = md_q ? CH_W'(DEEP_CH - 1) : '0;
    assign busy    = (state != ST_IDLE) && (state != ST_DONE);
    assign done    = (state == ST_DONE);
    assign result  = result_q;

    // Latch the tile description when a new tile is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_q    <= 1'b0;
            pr_q    <= '0;
            pc_q    <= '0;
            kern_q  <= '0;
            scale_q <= '0;
            abase_q <= '0;
            wbase_q <= '0;
        end else if (accept) begin
            md_q    <= deep_mode;
            pr_q    <= pool_row;
            pc_q    <= pool_col;
            kern_q  <= kern_idx;
            scale_q <= scale;
            abase_q <= act_base;
            wbase_q <= wgt_base;
        end
    end

    // Sequence fetch, drain, MAC steps and channels; register the pooled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fcnt     <= '0;
            mcnt     <= '0;
            ch       <= '0;
            result_q <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        state <= ST_FETCH;
                        fcnt  <= '0;
                        ch    <= '0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    if (fcnt == CNT_W'(WDIM - 1))
                        state <= ST_DRAIN;
                    else
                        fcnt <= fcnt + CNT_W'(1);
                end
                ST_DRAIN: begin
                    state <= ST_MAC;
                    mcnt  <= '0;
                end
                ST_MAC: begin
                    if (mcnt == CNT_W'(KDIM - 1)) begin
                        if (ch == last_ch) begin
                            state <= ST_POOL;
                        end else begin
                            ch    <= ch + CH_W'(1);
                            fcnt  <= '0;
                            state <= ST_FETCH;
                        end
                    end else begin
                        mcnt <= mcnt + CNT_W'(1);
                    end
                end
                ST_POOL: begin
                    result_q <= pooled;
                    state    <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Delay the fetch row by the memory latency to steer the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_row <= '0;
        end else begin
            cap_vld <= (state == ST_FETCH);
            cap_row <= fcnt;
        end
    end

    tile_addr_gen #(
        .ADDR_W(ADDR_W), .POS_W(POS_W), .KERN_W(KERN_W), .CH_W(CH_W),
        .DEEP_CH(DEEP_CH), .MAP_DIM(MAP_DIM),
        .WIDE_ROW_WORDS(WIDE_ROW_WORDS), .NARROW_ROW_WORDS(NARROW_ROW_WORDS)
    ) u_addr (
        .md(md_q), .pr(pr_q), .pc(pc_q), .kern(kern_q), .ch(ch), .frow(fcnt),
        .abase(abase_q), .wbase(wbase_q),
        .act_a0(act_addr0), .act_a1(act_addr1),
        .wgt_a0(wgt_addr0), .wgt_a1(wgt_addr1)
    );

    tile_window u_win (
        .clk(clk), .rst_n(rst_n), .cap_vld(cap_vld), .cap_row(cap_row),
        .col_odd(pc_q[0]),
        .act_rd0(act_rdata0), .act_rd1(act_rdata1),
        .wgt_rd0(wgt_rdata0), .wgt_rd1(wgt_rdata1),
        .win(win), .ker(ker)
    );

    tile_mac #(.ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(accept), .en(state == ST_MAC),
        .step_row(mcnt), .win(win), .ker(ker), .acc(acc)
    );

    tile_pool #(.ACC_W(ACC_W), .SC_W(SC_W), .SHIFT(SCALE_SHIFT)) u_pool (
        .acc(acc), .scale(scale_q), .pooled(pooled)
    );
endmodule

// File: rtl/tile_conv_pool_chk.sv
// Checker: handshake and output properties of the tile engine, bound to the
// top. Assumes reset is asserted from time zero.
module tile_conv_pool_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] result
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_BUSY_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R2
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(result)); // R4
    AST_RESULT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n) done |-> !result[7]); // R9
endmodule

bind tile_conv_pool tile_conv_pool_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .result(result)
);

// File: tb/sim_tile_conv_pool.sv
module sim_tile_conv_pool;
    localparam int CLK_PERIOD = 10;
    localparam int SH         = 16;
    localparam int ABASE      = 40;
    localparam int WBASE      = 20;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        deep_mode;
    logic [4:0]  pool_row;
    logic [4:0]  pool_col;
    logic [3:0]  kern_idx;
    logic [31:0] scale;
    logic [15:0] act_base;
    logic [15:0] wgt_base;
    logic [15:0] act_addr0, act_addr1, wgt_addr0, wgt_addr1;
    logic [31:0] act_rdata0, act_rdata1, wgt_rdata0, wgt_rdata1;
    logic        busy, done;
    logic [7:0]  result;

    logic [31:0] act_mem [0:1023];
    logic [31:0] wgt_mem [0:1023];

    int          n_chk = 0;
    int          n_bad = 0;
    int          phase = -1;
    int          cur_c = 1;
    int          cyc   = 0;
    bit          armed = 0;
    logic [7:0]  exp_res = '0;
    string       cur_tag = "";
    string       nxt_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_conv_pool u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .deep_mode(deep_mode),
        .pool_row(pool_row), .pool_col(pool_col), .kern_idx(kern_idx),
        .scale(scale), .act_base(act_base), .wgt_base(wgt_base),
        .act_addr0(act_addr0), .act_addr1(act_addr1),
        .act_rdata0(act_rdata0), .act_rdata1(act_rdata1),
        .wgt_addr0(wgt_addr0), .wgt_addr1(wgt_addr1),
        .wgt_rdata0(wgt_rdata0), .wgt_rdata1(wgt_rdata1),
        .busy(busy), .done(done), .result(result)
    );

    // Memories with one-cycle read latency.
    always @(posedge clk) begin
        act_rdata0 <= act_mem[act_addr0[9:0]];
        act_rdata1 <= act_mem[act_addr1[9:0]];
        wgt_rdata0 <= wgt_mem[wgt_addr0[9:0]];
        wgt_rdata1 <= wgt_mem[wgt_addr1[9:0]];
    end

    function automatic logic signed [7:0] get_byte(logic [31:0] w, int b);
        logic [31:0] t;
        t = w >> (8 * b);
        return t[7:0];
    endfunction

    // Behavioural expectation of one tile (R5..R9).
    function automatic logic [7:0] ref_tile(bit md, int pr, int pc, int k, int sc);
        int nc;
        int best;
        nc   = md ? 6 : 1;
        best = 0;
        for (int dy = 0; dy < 2; dy++) begin
            for (int dx = 0; dx < 2; dx++) begin
                int     acc;
                longint p;
                acc = 0;
                for (int c = 0; c < nc; c++) begin
                    for (int i = 0; i < 5; i++) begin
                        for (int j = 0; j < 5; j++) begin
                            int r, col, aw, ww;
                            r   = 2*pr + dy + i;
                            col = 2*pc + dx + j;
                            aw  = md ? ABASE + (c*14 + r)*4 + col/4 : ABASE + r*8 + col/4;
                            ww  = WBASE + ((k*nc + c)*5 + i)*2 + j/4;
                            acc = acc + int'(get_byte(act_mem[aw], col % 4)) *
                                        int'(get_byte(wgt_mem[ww], j % 4));
                        end
                    end
                end
                p = longint'(acc) * longint'(sc);
                p = (p + (longint'(1) << (SH - 1))) >>> SH;
                if (p > 127) p = 127;
                if (p < -128) p = -128;
                if (p < 0) p = 0;
                if (int'(p) > best) best = int'(p);
            end
        end
        return 8'(best);
    endfunction

    // Reference model of the handshake, advanced on every rising edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            phase = -1;
        end else if (start && (phase < 0 || phase == 12*cur_c + 1)) begin
            phase   = 0;
            cur_c   = deep_mode ? 6 : 1;
            exp_res = ref_tile(deep_mode, int'(pool_row), int'(pool_col), int'(kern_idx), int'(scale));
            cur_tag = nxt_tag;
        end else if (phase >= 0) begin
            phase = (phase == 12*cur_c + 1) ? -1 : phase + 1;
        end
    end

    // Compare busy/done every cycle and result on done (R2, R3, R10).
    always @(negedge clk) begin
        if (armed) begin
            logic eb, ed;
            eb = (phase >= 0) && (phase <= 12*cur_c);
            ed = (phase == 12*cur_c + 1);
            n_chk++;
            if (busy !== eb || done !== ed) begin
                n_bad++;
                $display("FAIL R2 busy/done act=%b/%b exp=%b/%b tile=%s", busy, done, eb, ed, cur_tag);
            end
            if (ed) begin
                n_chk++;
                if (result !== exp_res) begin
                    n_bad++;
                    $display("FAIL %s result act=%0d exp=%0d", cur_tag, result, exp_res);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            n_bad++;
            $display("FAIL R2 watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic launch(bit md, int pr, int pc, int k, int sc, string tag);
        deep_mode = md;
        pool_row  = 5'(pr);
        pool_col  = 5'(pc);
        kern_idx  = 4'(k);
        scale     = 32'(sc);
        nxt_tag   = tag;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    task automatic gap();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; deep_mode = 1'b0;
        pool_row = '0; pool_col = '0; kern_idx = '0; scale = '0;
        act_base = 16'(ABASE); wgt_base = 16'(WBASE);
        for (int i = 0; i < 1024; i++) begin
            act_mem[i] = $urandom;
            wgt_mem[i] = (i % 2 == 1) ? {24'h0, 8'($urandom)} : $urandom;
        end
        repeat (3) @(negedge clk);
        n_chk++;
        if (busy !== 1'b0 || done !== 1'b0 || result !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 in reset act=%b/%b/%0d exp=0/0/0", busy, done, result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (busy !== 1'b0 || done !== 1'b0 || result !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 after reset act=%b/%b/%0d exp=0/0/0", busy, done, result);
        end
        armed = 1;

        launch(0, 0, 0, 0, 150, "R5 R7 R8 shallow origin");   wait_done(); gap();
        launch(0, 13, 13, 5, 150, "R5 R8 shallow far odd");   wait_done(); gap();
        launch(0, 7, 6, 2, 200, "R5 R8 shallow even col");    wait_done(); gap();
        launch(1, 0, 0, 0, 80, "R6 R7 R8 deep origin");       wait_done(); gap();
        launch(1, 4, 3, 15, 80, "R6 R7 deep last kernel");    wait_done(); gap();
        launch(1, 2, 1, 7, 5000, "R9 saturate high");         wait_done(); gap();
        launch(1, 1, 2, 9, -200, "R9 negative scale");        wait_done(); gap();
        launch(0, 3, 9, 1, 1, "R9 rounding small scale");     wait_done(); gap();

        // R3 and R4: restart request and changed inputs during a tile.
        launch(1, 3, 4, 11, 90, "R3 R4 perturbed tile");
        repeat (3) @(negedge clk);
        deep_mode = 1'b0; pool_row = 5'd9; pool_col = 5'd2; kern_idx = 4'd3;
        scale = 32'd7000; act_base = 16'd0; wgt_base = 16'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        act_base = 16'(ABASE); wgt_base = 16'(WBASE);
        gap();

        // R10: next tile requested in the done cycle.
        launch(0, 5, 5, 4, 160, "R10 first of pair");
        wait_done();
        launch(1, 4, 4, 12, 70, "R10 back-to-back");
        wait_done();
        launch(0, 12, 0, 3, 140, "R10 third in a row");
        wait_done();
        repeat (4) @(negedge clk);

        armed = 0;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule